// File: doc/BRIEF.md
# Random Number Generator Command and Status Controller

This block sits between a host bus and a random number generator. The host writes 32-bit command words to a control location and reads a byte-wide status code from a second location. The block runs a fixed bring-up sequence: a reset that the block acknowledges, a release, an enable, and a zeroize step that runs a startup self-test and reports pass or fail. Once the host acknowledges a passing startup, the block produces one 32-bit random word at a time. Each word is published only after the host has acknowledged the previous read and enabled the block again.

The entropy source here is a stand-in: a 32-bit linear feedback shift register. The self-test verdict comes from the `selftest_pass` input, which is sampled when the test time runs out. The test time and the word generation time are parameterised cycle counts. Any write that is not a defined command, or that arrives out of order, leaves the block unchanged.

Top module: `rng_host_ctrl`

## Requirements
- R1: With `bus_rd` high, address 0x0 returns the current random word and address 0x4 returns the status code in bits 7:0 with bits 31:8 zero. With `bus_rd` low, `bus_rdata` is zero.
- R2: After power-on reset the status is 0x00 and the random word is zero. A write of 0x00000001 to address 0x0 in any state sets the status to 0xAC (reset acknowledged) on the next cycle.
- R3: Bring-up goes through three commands in a fixed order. 0x00000002 (release) is accepted only in the reset-acknowledged state. 0x80000000 (enable) is then accepted. 0x80000004 (zeroize) is accepted only after that enable.
- R4: Zeroize clears the random word to zero. The status reads 0x00 while the test runs. After exactly TEST_CYCLES cycles the status becomes 0x57 if `selftest_pass` is high, or 0xFA if it is low.
- R5: In the 0x57 state, 0x80000008 (startup acknowledge) starts generation. The status stays 0x00 for GEN_CYCLES cycles and then becomes 0xED (word ready), with a new word at address 0x0.
- R6: In the 0xED state, 0x8000000F (read acknowledge) sets the status to 0x00 and holds the word. No new word is produced until 0x80000000 (enable) is written. The status becomes 0xED again GEN_CYCLES cycles after that enable.
- R7: Each newly published word is non-zero and differs from the previous word. The word is stable between publications.
- R8: In the 0xFA state, every command except reset is ignored, so the status stays 0xFA until a reset command arrives.
- R9: A write is ignored and changes no state or output in any of these cases: the data matches no command code, the write goes to address 0x4, or the command is defined but not valid in the current state.
- R10: TEST_CYCLES and GEN_CYCLES are parameters. The bench uses 16 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, enables `bus_rdata` |
| bus_addr | input | ADDR_W | Byte address: 0x0 is control and word, 0x4 is status |
| bus_wdata | input | 32 | Write data (command word) |
| bus_rdata | output | 32 | Read data, combinational from address |
| selftest_pass | input | 1 | Startup self-test verdict, sampled when the test time expires |

## Verification
Three situations can only be reached after the full bring-up sequence has been replayed from the ports: the ready state, the waiting-for-enable state and the sticky failure state. Each bench task therefore starts from a reset command and walks the block through release, enable, zeroize and startup acknowledge before it applies its stimulus. The hardest check is that a read acknowledge without a following enable never produces a new word. The bench holds the block in that state for longer than GEN_CYCLES and confirms that the status and the word are both unchanged. It also fires stray, misaddressed and out-of-order commands into the ready and reset-acknowledged states and checks that nothing moves.

// File: rtl/trng_ctrl_pkg.sv
// Package: shared command words, status codes and type definitions for the
// random number generator controller. Assumes 32-bit command words and 8-bit status codes.
package trng_ctrl_pkg;

    localparam logic [31:0] CMD_RESET   = 32'h0000_0001;
    localparam logic [31:0] CMD_RELEASE = 32'h0000_0002;
    localparam logic [31:0] CMD_ENABLE  = 32'h8000_0000;
    localparam logic [31:0] CMD_ZEROIZE = 32'h8000_0004;
    localparam logic [31:0] CMD_ACK_ZER = 32'h8000_0008;
    localparam logic [31:0] CMD_RD_ACK  = 32'h8000_000F;

    localparam logic [7:0] STS_BUSY    = 8'h00;
    localparam logic [7:0] STS_RST_ACK = 8'hAC;
    localparam logic [7:0] STS_BOOT_OK = 8'h57;
    localparam logic [7:0] STS_BOOT_NG = 8'hFA;
    localparam logic [7:0] STS_READY   = 8'hED;

    typedef enum logic [2:0] {
        OP_NONE, OP_RESET, OP_RELEASE, OP_ENABLE, OP_ZEROIZE, OP_ACK_ZER, OP_RD_ACK
    } op_e;

    typedef enum logic [3:0] {
        LC_IDLE, LC_RST, LC_REL, LC_EN, LC_TEST, LC_OK, LC_FAIL, LC_GEN, LC_READY, LC_HOLD
    } lc_e;

    // Map a lifecycle state to the status byte reported to the host.
    function automatic logic [7:0] status_of(lc_e s);
        case (s)
            LC_RST:   return STS_RST_ACK;
            LC_OK:    return STS_BOOT_OK;
            LC_FAIL:  return STS_BOOT_NG;
            LC_READY: return STS_READY;
            default:  return STS_BUSY;
        endcase
    endfunction

endpackage

// File: rtl/trng_cmd_decode.sv
// Module: turns a bus write into one decoded operation.
// Assumes one-cycle write strobes. Only writes to CTRL_OFS whose data match
// a command code exactly produce an operation; everything else is OP_NONE.
module trng_cmd_decode
    import trng_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFS = 0
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output op_e               op
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    // Exact-match decode of the command word.
    always_comb begin
        op = OP_NONE;
        if (wr && addr == CTRL_A) begin
            case (wdata)
                CMD_RESET:   op = OP_RESET;
                CMD_RELEASE: op = OP_RELEASE;
                CMD_ENABLE:  op = OP_ENABLE;
                CMD_ZEROIZE: op = OP_ZEROIZE;
                CMD_ACK_ZER: op = OP_ACK_ZER;
                CMD_RD_ACK:  op = OP_RD_ACK;
                default:     op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/trng_delay_timer.sv
// Module: one-shot down counter. A start with load value N raises done
// in the N-th cycle after the start edge, so a state change on done lands
// exactly N cycles after the start. Assumes N >= 1. Clear aborts a count.
module trng_delay_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          start,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;
    logic          active;

    assign done = active && (cnt == '0);

    // Load, count down and retire the one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= load_val - CW'(1);
            active <= 1'b1;
        end else if (done) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt - CW'(1);
        end
    end

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !clear) |=> !done)
        else $error("timer done lasted more than one cycle");

endmodule

// File: rtl/trng_lfsr_source.sv
// Module: stand-in entropy source, a Galois LFSR stepped on demand.
// Assumes a non-zero SEED and a maximal-length TAPS mask, so the state never reaches zero.
module trng_lfsr_source #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         reseed,
    output logic [W-1:0] q
);

    // Shift with feedback, or reload the seed.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) begin
            q <= SEED;
        end else if (step) begin
            q <= q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
        end
    end

    p_never_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (q != '0))
        else $error("lfsr reached zero");

endmodule

// File: rtl/trng_lifecycle_fsm.sv
// Module: bring-up and per-word handshake state machine. It owns the
// published random word and drives the shared delay timer and the source.
// Assumes at most one decoded operation per cycle; reset wins over all.
module trng_lifecycle_fsm
    import trng_ctrl_pkg::*;
#(
    parameter int TEST_CYCLES = 16,
    parameter int GEN_CYCLES  = 8,
    parameter int CW          = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic          selftest_pass,
    input  logic          tmr_done,
    input  logic [31:0]   src_q,
    output logic          tmr_clear,
    output logic          tmr_start,
    output logic [CW-1:0] tmr_val,
    output logic          src_step,
    output logic          src_reseed,
    output lc_e           state,
    output logic [31:0]   word
);

    lc_e nxt;

    // Next-state and timer control.
    always_comb begin
        nxt       = state;
        tmr_start = 1'b0;
        tmr_clear = 1'b0;
        tmr_val   = '0;
        if (op == OP_RESET) begin
            nxt       = LC_RST;
            tmr_clear = 1'b1;
        end else begin
            case (state)
                LC_RST:   if (op == OP_RELEASE) nxt = LC_REL;
                LC_REL:   if (op == OP_ENABLE)  nxt = LC_EN;
                LC_EN: if (op == OP_ZEROIZE) begin
                    nxt       = LC_TEST;
                    tmr_start = 1'b1;
                    tmr_val   = CW'(TEST_CYCLES);
                end
                LC_TEST:  if (tmr_done) nxt = selftest_pass ? LC_OK : LC_FAIL;
                LC_OK: if (op == OP_ACK_ZER) begin
                    nxt       = LC_GEN;
                    tmr_start = 1'b1;
                    tmr_val   = CW'(GEN_CYCLES);
                end
                LC_GEN:   if (tmr_done) nxt = LC_READY;
                LC_READY: if (op == OP_RD_ACK) nxt = LC_HOLD;
                LC_HOLD: if (op == OP_ENABLE) begin
                    nxt       = LC_GEN;
                    tmr_start = 1'b1;
                    tmr_val   = CW'(GEN_CYCLES);
                end
                default:  nxt = state;
            endcase
        end
    end

    assign src_step   = (state == LC_GEN);
    assign src_reseed = (state == LC_EN) && (op == OP_ZEROIZE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LC_IDLE;
        else        state <= nxt;
    end

    // Published word: cleared by zeroize, captured when generation ends.
    always_ff @(posedge clk) begin
        if (!rst_n || src_reseed)                        word <= '0;
        else if (state == LC_GEN && tmr_done && op != OP_RESET) word <= src_q;
    end

    p_reset_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESET) |=> (state == LC_RST))
        else $error("reset command not acknowledged");

    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LC_FAIL && op != OP_RESET) |=> (state == LC_FAIL))
        else $error("left failed state without reset");

    p_hold_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LC_HOLD && op != OP_ENABLE && op != OP_RESET) |=> (state == LC_HOLD && $stable(word)))
        else $error("new word without enable");

    p_fresh_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LC_GEN && tmr_done && op != OP_RESET) |=> (state == LC_READY && word != $past(word)))
        else $error("published word not fresh");

    p_ignore_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && !tmr_done) |=> $stable(state))
        else $error("state moved without command");

endmodule

// File: rtl/rng_host_ctrl.sv
// Module: top of the random number generator controller. It decodes bus
// writes, runs the lifecycle FSM with a shared delay timer and an LFSR
// stand-in source, and returns the word or the status on reads.
// Assumes a simple one-cycle write strobe and combinational read data.
module rng_host_ctrl
    import trng_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int TEST_CYCLES = 16,
    parameter int GEN_CYCLES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              selftest_pass
);

    localparam int MAXC = (TEST_CYCLES > GEN_CYCLES) ? TEST_CYCLES : GEN_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(4);

    op_e           op;
    lc_e           state;
    logic          tmr_clear, tmr_start, tmr_done;
    logic [CW-1:0] tmr_val;
    logic          src_step, src_reseed;
    logic [31:0]   src_q, word;

    trng_cmd_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(0)) u_dec (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .op(op)
    );

    trng_delay_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .start(tmr_start),
        .load_val(tmr_val), .done(tmr_done)
    );

    trng_lfsr_source #(.W(32)) u_src (
        .clk(clk), .rst_n(rst_n), .step(src_step), .reseed(src_reseed), .q(src_q)
    );

    trng_lifecycle_fsm #(.TEST_CYCLES(TEST_CYCLES), .GEN_CYCLES(GEN_CYCLES), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .op(op), .selftest_pass(selftest_pass),
        .tmr_done(tmr_done), .src_q(src_q), .tmr_clear(tmr_clear),
        .tmr_start(tmr_start), .tmr_val(tmr_val), .src_step(src_step),
        .src_reseed(src_reseed), .state(state), .word(word)
    );

    // Read mux: word at 0x0, status byte at 0x4, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == WORD_A)      bus_rdata = word;
            else if (bus_addr == STAT_A) bus_rdata = {24'h0, status_of(state)};
        end
    end

    p_idle_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0))
        else $error("read data driven without read strobe");

endmodule

// File: tb/rng_host_ctrl_tb.sv
module rng_host_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TEST_N = 16;
    localparam int GEN_N  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        selftest_pass = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rng_host_ctrl #(.ADDR_W(4), .TEST_CYCLES(TEST_N), .GEN_CYCLES(GEN_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .selftest_pass(selftest_pass)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_ne(input string tag, input logic [31:0] got, input logic [31:0] bad);
        checks++;
        if (got === bad) begin
            errors++;
            $display("FAIL %s: got %h expected not %h", tag, got, bad);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset, release, enable, zeroize, wait for test verdict.
    task automatic bring_up(input logic pass, input logic [31:0] exp_sts);
        logic [31:0] v;
        selftest_pass = pass;
        wr(4'h0, 32'h0000_0001);
        rd(4'h4, v); check("R2 reset ack", v, 32'hAC);
        wr(4'h0, 32'h0000_0002);
        wr(4'h0, 32'h8000_0000);
        wr(4'h0, 32'h8000_0004);
        rd(4'h4, v); check("R4 busy during test", v, 32'h00);
        rd(4'h0, v); check("R4 word zeroized", v, 32'h0);
        wait_cyc(TEST_N - 1);
        rd(4'h4, v); check("R4 still testing at N-1", v, 32'h00);
        wait_cyc(1);
        rd(4'h4, v); check("R4 test verdict", v, exp_sts);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(4'h4, v); check("R2 power-on status", v, 32'h00);
        rd(4'h0, v); check("R2 power-on word", v, 32'h0);
        bus_addr = 4'h4; #1;
        check("R1 rdata zero without strobe", bus_rdata, 32'h0);
        rd(4'h8, v); check("R1 unmapped address reads zero", v, 32'h0);
    endtask

    task automatic t_generate();
        logic [31:0] v, w_prev, w;
        bring_up(1'b1, 32'h57);
        wr(4'h0, 32'h8000_0008);
        rd(4'h4, v); check("R5 busy after startup ack", v, 32'h00);
        wait_cyc(GEN_N - 1);
        rd(4'h4, v); check("R5 busy at GEN-1", v, 32'h00);
        wait_cyc(1);
        rd(4'h4, v); check("R5 ready", v, 32'hED);
        rd(4'h0, w_prev); check_ne("R7 first word non-zero", w_prev, 32'h0);
        wait_cyc(3);
        rd(4'h0, v); check("R7 word stable while ready", v, w_prev);
        for (int k = 0; k < 3; k++) begin
            wr(4'h0, 32'h8000_000F);
            rd(4'h4, v); check("R6 busy after read ack", v, 32'h00);
            wait_cyc(GEN_N + 4);
            rd(4'h4, v); check("R6 no word without enable", v, 32'h00);
            rd(4'h0, v); check("R6 word held", v, w_prev);
            wr(4'h0, 32'h8000_0000);
            wait_cyc(GEN_N - 1);
            rd(4'h4, v); check("R6 busy before GEN", v, 32'h00);
            wait_cyc(1);
            rd(4'h4, v); check("R6 ready again", v, 32'hED);
            rd(4'h0, w);
            check_ne("R7 word differs", w, w_prev);
            check_ne("R7 word non-zero", w, 32'h0);
            w_prev = w;
        end
    endtask

    task automatic t_ignored();
        logic [31:0] v, w0;
        rd(4'h0, w0);
        wr(4'h0, 32'h1234_5678);
        rd(4'h4, v); check("R9 unknown code ignored", v, 32'hED);
        wr(4'h4, 32'h8000_000F);
        rd(4'h4, v); check("R9 write to status ignored", v, 32'hED);
        wr(4'h0, 32'h8000_0000);
        wait_cyc(GEN_N + 2);
        rd(4'h4, v); check("R9 enable while ready ignored", v, 32'hED);
        rd(4'h0, v); check("R9 word unchanged", v, w0);
        wr(4'h0, 32'h0000_0001);
        wr(4'h0, 32'h8000_0004);
        rd(4'h4, v); check("R3 zeroize before release ignored", v, 32'hAC);
        wr(4'h0, 32'h8000_0000);
        rd(4'h4, v); check("R3 enable before release ignored", v, 32'hAC);
        rd(4'h0, v); check("R9 word kept after misorder", v, w0);
    endtask

    task automatic t_fail();
        logic [31:0] v;
        bring_up(1'b0, 32'hFA);
        wr(4'h0, 32'h8000_0000);
        wr(4'h0, 32'h8000_000F);
        wr(4'h0, 32'h8000_0008);
        wait_cyc(GEN_N + 2);
        rd(4'h4, v); check("R8 failed state sticky", v, 32'hFA);
        wr(4'h0, 32'h0000_0001);
        rd(4'h4, v); check("R8 reset leaves failed state", v, 32'hAC);
    endtask

    task automatic t_reset_midway();
        logic [31:0] v;
        bring_up(1'b1, 32'h57);
        wr(4'h0, 32'h8000_0008);
        wait_cyc(2);
        wr(4'h0, 32'h0000_0001);
        rd(4'h4, v); check("R2 reset during generation", v, 32'hAC);
        wait_cyc(GEN_N + 2);
        rd(4'h4, v); check("R2 reset aborts generation", v, 32'hAC);
        rd(4'h0, v); check("R4 word still zero after abort", v, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_generate();
        t_ignored();
        t_fail();
        t_reset_midway();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule